// File: doc/BRIEF.md
# Multi-core reset and boot-release controller

This block sits on a 32-bit register bus inside a 4 KB address window. It lets software release, stop and reset up to four processor cores and reset two peripheral subsystems. Cores 1 to 3 can be switched on and off. When a core is switched on, it receives a start address and an argument. Each of these comes from a pair of general-purpose registers assigned to that core. Core 0 can only be reset.

Only writes to the control word cause actions. Each control write is compared with the value already stored, and only the bits that differ take effect. An enable bit that flips powers its core on or off, and it also cancels any reset request for that core in the same write. A reset request bit that flips produces a one-cycle reset pulse and is then stored as zero, so it never stays set.

All other registers simply hold the word written to them. They are the reset-status word, the interrupt-mask word, two boot-mode words and ten general-purpose words.

Top module: `core_release_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero except three: index 0 (control) reads 0x521, index 2 (reset status) reads 0x1 and index 3 (interrupt mask) reads 0x1F.
- R2: The register index is the byte address shifted right by two. Indices 0 to 14 hold control, boot mode A, reset status, interrupt mask, boot mode B, then general-purpose words 1 to 10. Read data appears combinationally in the same cycle. Reads of index 15 or above return zero, and a cycle with no read request also returns zero.
- R3: An access is taken only when all four byte enables are set and address bits [1:0] are zero. Any other write changes no register and produces no pulse, and any other read returns zero.
- R4: A write to any index other than 0 stores the word unchanged and produces no output pulse.
- R5: On a control write where the enable bit of core c (bit 21+c, for c = 1..3) changes, the cycle after the write carries a one-cycle pulse on `pwr_on[c]` if the new bit is 1, or on `pwr_off[c]` if it is 0. Bit 0 of both outputs is never set.
- R6: On a control write where the reset request bit of core c (bit 13+c, c = 0..3) changes, `core_rst[c]` pulses for one cycle in the cycle after the write, and the bit is stored as 0.
- R7: If the enable bit of a core changes in the same write, that core's reset request bit is stored as 0 and no `core_rst` pulse is issued for it.
- R8: On a control write where peripheral reset bit 3 or bit 12 changes, `periph_rst[0]` or `periph_rst[1]` respectively pulses for one cycle in the cycle after the write, and the bit is stored as 0.
- R9: All other control bits are stored exactly as written. A control write whose value equals the stored value produces no pulse.
- R10: On power-on of core c, slice c of `core_start_addr` and `core_arg` (bits 32c+31:32c) takes the values that general-purpose words 2c+1 and 2c+2 (indices 5+2c and 6+2c) held before the write. The slice then stays at that value until the next power-on of the same core. Slice 0 is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address inside the window |
| req_be | input | 4 | Byte enables; all four are required |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Combinational read data |
| pwr_on | output | 4 | Per-core power-on pulse |
| pwr_off | output | 4 | Per-core power-off pulse |
| core_rst | output | 4 | Per-core reset pulse |
| periph_rst | output | 2 | Peripheral reset pulse |
| core_start_addr | output | 128 | Per-core start address, 32 bits per core |
| core_arg | output | 128 | Per-core boot argument, 32 bits per core |

## Verification
The in-line properties check several rules on every cycle. Power-on and power-off never coincide for one core, and core 0 is never powered. No pulse appears unless a control write was taken in the previous cycle. The stored reset-request and peripheral bits are always zero. A rejected write leaves every register unchanged. Start addresses and arguments hold between power-on events. Other behaviour depends on the write history and is shown only by the bench, which runs directed scenarios and a long pseudo-random write mix against a behavioural model. That behaviour covers which core reacts to which changed bit, the sampling of the general-purpose pair before the write, a reset request cancelled by a simultaneous enable change, and the absence of action when the written value equals the stored one.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int DATA_W     = 32;
    localparam int NUM_CORES  = 4;
    localparam int NUM_PERIPH = 2;
    localparam int NUM_REGS   = 15;
    localparam int RIDX_W     = $clog2(NUM_REGS);

    // register indices
    localparam int IDX_CTRL     = 0;
    localparam int IDX_BOOT_A   = 1;
    localparam int IDX_RST_STAT = 2;
    localparam int IDX_IRQ_MASK = 3;
    localparam int IDX_BOOT_B   = 4;
    localparam int IDX_GPR1     = 5;

    // control word bit layout
    localparam int CORE_RST_LSB = 13;   // core c reset request at 13+c
    localparam int CORE_EN_BASE = 21;   // core c enable at 21+c, c >= 1

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic [NUM_CORES-1:0]  pwr_on;
        logic [NUM_CORES-1:0]  pwr_off;
        logic [NUM_CORES-1:0]  core_rst;
        logic [NUM_PERIPH-1:0] periph_rst;
    } ctrl_pulse_t;

    function automatic int periph_bit(input int p);
        return (p == 0) ? 3 : 12;
    endfunction

    function automatic word_t reg_reset_value(input int idx);
        case (idx)
            IDX_CTRL:     return word_t'(32'h0000_0521);
            IDX_RST_STAT: return word_t'(32'h0000_0001);
            IDX_IRQ_MASK: return word_t'(32'h0000_001F);
            default:      return '0;
        endcase
    endfunction

    function automatic int start_gpr_idx(input int core);
        return IDX_GPR1 + 2 * core;
    endfunction

    function automatic int arg_gpr_idx(input int core);
        return IDX_GPR1 + 2 * core + 1;
    endfunction

endpackage

// File: rtl/crc_bus_decode.sv
module crc_bus_decode
    import crc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic [RIDX_W-1:0] idx
);
    localparam int FULL_W = ADDR_W - 2;

    logic [FULL_W-1:0] full_idx;
    logic              aligned;
    logic              in_range;

    assign full_idx = req_addr[ADDR_W-1:2];
    assign aligned  = (req_addr[1:0] == 2'b00) && (req_be == 4'hF);
    assign in_range = (full_idx < FULL_W'(NUM_REGS));
    assign idx      = full_idx[RIDX_W-1:0];
    assign rd_ok    = req_valid && !req_write && aligned && in_range;
    assign wr_ok    = req_valid &&  req_write && aligned && in_range;
endmodule

// File: rtl/crc_regfile.sv
module crc_regfile
    import crc_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [RIDX_W-1:0]                wr_idx,
    input  word_t                            wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= reg_reset_value(i);
            end else if (wr_en && (wr_idx == RIDX_W'(i))) begin
                regs_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/crc_ctrl_decode.sv
module crc_ctrl_decode
    import crc_pkg::*;
(
    input  word_t       old_val,
    input  word_t       new_val,
    output ctrl_pulse_t act,
    output word_t       store_val
);
    word_t chg;
    word_t v;

    always_comb begin
        v   = new_val;
        chg = old_val ^ new_val;
        act = '0;
        // enable changes, highest core first; each cancels that core's reset
        for (int c = NUM_CORES - 1; c >= 1; c--) begin
            if (chg[CORE_EN_BASE + c]) begin
                act.pwr_on[c]         = v[CORE_EN_BASE + c];
                act.pwr_off[c]        = ~v[CORE_EN_BASE + c];
                v[CORE_RST_LSB + c]   = 1'b0;
                chg[CORE_RST_LSB + c] = 1'b0;
            end
        end
        // remaining reset requests, core 0 upward
        for (int c = 0; c < NUM_CORES; c++) begin
            if (chg[CORE_RST_LSB + c]) begin
                act.core_rst[c]     = 1'b1;
                v[CORE_RST_LSB + c] = 1'b0;
            end
        end
        for (int p = 0; p < NUM_PERIPH; p++) begin
            if (chg[periph_bit(p)]) begin
                act.periph_rst[p]  = 1'b1;
                v[periph_bit(p)]   = 1'b0;
            end
        end
        store_val = v;
    end
endmodule

// File: rtl/crc_pulse_out.sv
module crc_pulse_out
    import crc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              fire,
    input  ctrl_pulse_t                       act,
    input  logic [NUM_CORES-1:0][DATA_W-1:0]  start_in,
    input  logic [NUM_CORES-1:0][DATA_W-1:0]  arg_in,
    output ctrl_pulse_t                       pulse_q,
    output logic [NUM_CORES-1:0][DATA_W-1:0]  start_q,
    output logic [NUM_CORES-1:0][DATA_W-1:0]  arg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= fire ? act : '0;
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        if (c == 0) begin : g_no_boot
            assign start_q[c] = '0;
            assign arg_q[c]   = '0;
        end else begin : g_boot
            always_ff @(posedge clk) begin
                if (rst) begin
                    start_q[c] <= '0;
                    arg_q[c]   <= '0;
                end else if (fire && act.pwr_on[c]) begin
                    start_q[c] <= start_in[c];
                    arg_q[c]   <= arg_in[c];
                end
            end
        end
    end
endmodule

// File: rtl/core_release_ctrl.sv
module core_release_ctrl
    import crc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [3:0]                    req_be,
    input  logic [DATA_W-1:0]             req_wdata,
    output logic [DATA_W-1:0]             rsp_rdata,
    output logic [NUM_CORES-1:0]          pwr_on,
    output logic [NUM_CORES-1:0]          pwr_off,
    output logic [NUM_CORES-1:0]          core_rst,
    output logic [NUM_PERIPH-1:0]         periph_rst,
    output logic [NUM_CORES*DATA_W-1:0]   core_start_addr,
    output logic [NUM_CORES*DATA_W-1:0]   core_arg
);
    logic                              rd_ok;
    logic                              wr_ok;
    logic [RIDX_W-1:0]                 idx;
    logic [NUM_REGS-1:0][DATA_W-1:0]   regs_q;
    logic                              ctrl_fire;
    word_t                             wr_data;
    word_t                             ctrl_next;
    ctrl_pulse_t                       act;
    ctrl_pulse_t                       pulse_q;
    logic [NUM_CORES-1:0][DATA_W-1:0]  start_in;
    logic [NUM_CORES-1:0][DATA_W-1:0]  arg_in;
    logic [NUM_CORES-1:0][DATA_W-1:0]  start_q;
    logic [NUM_CORES-1:0][DATA_W-1:0]  arg_q;

    crc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok),
        .idx       (idx)
    );

    crc_ctrl_decode u_ctrl (
        .old_val   (regs_q[IDX_CTRL]),
        .new_val   (req_wdata),
        .act       (act),
        .store_val (ctrl_next)
    );

    assign ctrl_fire = wr_ok && (idx == RIDX_W'(IDX_CTRL));
    assign wr_data   = ctrl_fire ? ctrl_next : req_wdata;

    crc_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ok),
        .wr_idx  (idx),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_src
        if (c == 0) begin : g_none
            assign start_in[c] = '0;
            assign arg_in[c]   = '0;
        end else begin : g_pair
            assign start_in[c] = regs_q[start_gpr_idx(c)];
            assign arg_in[c]   = regs_q[arg_gpr_idx(c)];
        end
    end

    crc_pulse_out u_out (
        .clk      (clk),
        .rst      (rst),
        .fire     (ctrl_fire),
        .act      (act),
        .start_in (start_in),
        .arg_in   (arg_in),
        .pulse_q  (pulse_q),
        .start_q  (start_q),
        .arg_q    (arg_q)
    );

    assign rsp_rdata       = rd_ok ? regs_q[idx] : '0;
    assign pwr_on          = pulse_q.pwr_on;
    assign pwr_off         = pulse_q.pwr_off;
    assign core_rst        = pulse_q.core_rst;
    assign periph_rst      = pulse_q.periph_rst;
    assign core_start_addr = start_q;
    assign core_arg        = arg_q;

    // ---------------- assertions ----------------
    localparam word_t CORE_RST_MASK = word_t'({NUM_CORES{1'b1}}) << CORE_RST_LSB;
    localparam word_t PERIPH_MASK   = (word_t'(1) << periph_bit(0)) | (word_t'(1) << periph_bit(1));

    AST_ON_OFF_EXCL: assert property (@(posedge clk) disable iff (rst)
        (pwr_on & pwr_off) == '0);                                        // R5
    AST_CORE0_NO_PWR: assert property (@(posedge clk) disable iff (rst)
        !pwr_on[0] && !pwr_off[0]);                                       // R5
    AST_PULSE_AFTER_CTRL_WR: assert property (@(posedge clk) disable iff (rst)
        (|{pwr_on, pwr_off, core_rst, periph_rst}) |-> $past(ctrl_fire)); // R6
    AST_CORE_RST_BITS_LOW: assert property (@(posedge clk) disable iff (rst)
        (regs_q[IDX_CTRL] & CORE_RST_MASK) == '0);                        // R6
    AST_EN_CANCELS_RST: assert property (@(posedge clk) disable iff (rst)
        ((pwr_on | pwr_off) & core_rst) == '0);                           // R7
    AST_PERIPH_BITS_LOW: assert property (@(posedge clk) disable iff (rst)
        (regs_q[IDX_CTRL] & PERIPH_MASK) == '0);                          // R8
    AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && (req_be != 4'hF || req_addr[1:0] != 2'b00))
        |=> $stable(regs_q));                                             // R3
    AST_BOOT_INFO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pwr_on == '0) |-> ($stable(core_start_addr) && $stable(core_arg))); // R10
endmodule

// File: tb/sim_core_release_ctrl.sv
module sim_core_release_ctrl;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [3:0]   req_be = '0;
    logic [31:0]  req_wdata = '0;
    logic [31:0]  rsp_rdata;
    logic [3:0]   pwr_on, pwr_off, core_rst;
    logic [1:0]   periph_rst;
    logic [127:0] core_start_addr, core_arg;

    core_release_ctrl #(.ADDR_W(12)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .pwr_on(pwr_on), .pwr_off(pwr_off),
        .core_rst(core_rst), .periph_rst(periph_rst),
        .core_start_addr(core_start_addr), .core_arg(core_arg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0]  m_regs [15];
    logic [3:0]   e_on, e_off, e_crst;
    logic [1:0]   e_prst;
    logic [127:0] e_addr, e_arg;
    logic [31:0]  mv, mc;
    int           midx;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 15; i++) m_regs[i] = 32'h0;
            m_regs[0] = 32'h521; m_regs[2] = 32'h1; m_regs[3] = 32'h1F;
            e_on = 0; e_off = 0; e_crst = 0; e_prst = 0; e_addr = 0; e_arg = 0;
        end else begin
            e_on = 0; e_off = 0; e_crst = 0; e_prst = 0;
            midx = int'(req_addr >> 2);
            if (req_valid && req_write && req_be == 4'hF && req_addr[1:0] == 2'b00 && midx < 15) begin
                if (midx == 0) begin
                    mv = req_wdata;
                    mc = m_regs[0] ^ req_wdata;
                    for (int c = 3; c >= 1; c--) begin
                        if (mc[21+c]) begin
                            if (mv[21+c]) begin
                                e_on[c] = 1'b1;
                                e_addr[32*c +: 32] = m_regs[5 + 2*c];
                                e_arg[32*c +: 32]  = m_regs[6 + 2*c];
                            end else e_off[c] = 1'b1;
                            mv[13+c] = 1'b0; mc[13+c] = 1'b0;
                        end
                    end
                    for (int c = 0; c < 4; c++)
                        if (mc[13+c]) begin e_crst[c] = 1'b1; mv[13+c] = 1'b0; end
                    if (mc[3])  begin e_prst[0] = 1'b1; mv[3] = 1'b0; end
                    if (mc[12]) begin e_prst[1] = 1'b1; mv[12] = 1'b0; end
                    m_regs[0] = mv;
                end else begin
                    m_regs[midx] = req_wdata;
                end
            end
        end
    end

    // per-cycle comparison, away from the clock edge
    logic [31:0] exp_rd;
    int          cidx;
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            cidx = int'(req_addr >> 2);
            exp_rd = (req_valid && !req_write && req_be == 4'hF && req_addr[1:0] == 2'b00 && cidx < 15)
                     ? m_regs[cidx] : 32'h0;
            chk("R2 read data", rsp_rdata, exp_rd);
            chk("R5 pwr_on", pwr_on, e_on);
            chk("R5 pwr_off", pwr_off, e_off);
            chk("R6 core_rst", core_rst, e_crst);
            chk("R8 periph_rst", periph_rst, e_prst);
            chk("R10 start addr", core_start_addr, e_addr);
            chk("R10 argument", core_arg, e_arg);
        end
    end

    // ---------------- drivers ----------------
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        #1;
        d = rsp_rdata;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    logic [31:0] d;
    logic [31:0] lfsr = 32'hACE1_2468;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset values, R2 indexing and out-of-range reads
        for (int i = 0; i < 15; i++) begin
            rd(12'(i*4), d);
            chk("R1 reset value", d, (i == 0) ? 32'h521 : (i == 2) ? 32'h1 : (i == 3) ? 32'h1F : 32'h0);
        end
        rd(12'h03C, d); chk("R2 index 15 reads zero", d, 0);
        rd(12'hFFC, d); chk("R2 top of window reads zero", d, 0);

        // R4 general-purpose words
        for (int k = 1; k <= 10; k++) wr(12'((4 + k) * 4), 32'h1000_0000 + k * 32'h111);
        wr(12'h004, 32'hB007_000A); wr(12'h008, 32'h5A5A_0000);
        chk("R4 no pulse on plain write", {pwr_on, pwr_off, core_rst, periph_rst}, 0);
        rd(12'h01C, d); chk("R4 GPR3 stored", d, 32'h1000_0333);
        rd(12'h008, d); chk("R4 status stored", d, 32'h5A5A_0000);

        // R3 illegal accesses
        wr(12'h014, 32'hDEAD_BEEF, 4'h7);
        rd(12'h014, d); chk("R3 partial write ignored", d, 32'h1000_0111);
        wr(12'h016, 32'hDEAD_BEEF);
        rd(12'h014, d); chk("R3 misaligned write ignored", d, 32'h1000_0111);
        rd(12'h014, d, 4'h3); chk("R3 partial read returns zero", d, 0);
        wr(12'h000, 32'h0040_0521, 4'hE);
        chk("R3 bad control write no pulse", pwr_on, 0);
        wr(12'h03C, 32'h1234_5678);
        rd(12'h03C, d); chk("R3 out-of-range write dropped", d, 0);

        // R5 power on core 1 with its pair
        wr(12'h000, 32'h0040_0521);
        chk("R5 core1 on", pwr_on, 4'b0010);
        chk("R10 core1 start", core_start_addr[63:32], 32'h1000_0333);
        chk("R10 core1 arg", core_arg[63:32], 32'h1000_0444);
        // R9 same value: nothing
        wr(12'h000, 32'h0040_0521);
        chk("R9 repeat write no pulse", {pwr_on, pwr_off, core_rst, periph_rst}, 0);

        // R7 disable core1 with its reset bit set
        wr(12'h000, 32'h0000_4521);
        chk("R7 core1 off", pwr_off, 4'b0010);
        chk("R7 no reset pulse", core_rst, 0);
        rd(12'h000, d); chk("R7 reset bit stored low", d, 32'h0000_0521);

        // R6 all core resets
        wr(12'h000, 32'h0001_E521);
        chk("R6 all cores reset", core_rst, 4'hF);
        rd(12'h000, d); chk("R6 reset bits self-clear", d, 32'h0000_0521);

        // R8 peripherals
        wr(12'h000, 32'h0000_1529);
        chk("R8 both peripherals", periph_rst, 2'b11);
        rd(12'h000, d); chk("R8 bits self-clear", d, 32'h0000_0521);

        // cores 2 and 3 on, core1 reset in same write
        wr(12'h000, 32'h0180_4521);
        chk("R5 cores 2 and 3 on", pwr_on, 4'b1100);
        chk("R6 core1 reset alongside", core_rst, 4'b0010);
        chk("R10 core3 start", core_start_addr[127:96], 32'h1000_0777);

        // R10 hold and reload
        wr(12'h024, 32'hCAFE_0000);
        chk("R10 core2 start held", core_start_addr[95:64], 32'h1000_0555);
        wr(12'h000, 32'h0100_0521);
        chk("R5 core2 off", pwr_off, 4'b0100);
        wr(12'h000, 32'h0180_0521);
        chk("R10 core2 start reloaded", core_start_addr[95:64], 32'hCAFE_0000);

        // R9 other bits stored as written
        wr(12'h000, 32'h4180_0F21);
        chk("R9 no pulse for plain bits", {pwr_on, pwr_off, core_rst, periph_rst}, 0);
        rd(12'h000, d); chk("R9 plain bits stored", d, 32'h4180_0F21);

        // pseudo-random mix against the model
        for (int n = 0; n < 600; n++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            case (lfsr[2:0])
                3'd0, 3'd1, 3'd2: wr(12'h000, {7'h0, lfsr[24:22], 5'h0, lfsr[16:3], 3'h1} ^ 32'h0000_0520);
                3'd3: wr(12'((lfsr[11:8] % 15) * 4), lfsr);
                3'd4: wr({lfsr[11:2], lfsr[1:0]}, ~lfsr, lfsr[7:4]);
                default: rd({lfsr[11:2], 2'b00}, d);
            endcase
        end
        @(negedge clk); req_valid = 1'b0;
        repeat (3) @(negedge clk);

        summary();
        $finish;
    end
endmodule